// File: doc/BRIEF.md
# Flash Command and Status Front-End

This block is the register-level face of an embedded flash controller. Software reaches it through a simple 32-bit register bus with a select, a write strobe, a byte address and write data. Read data is combinational. Behind the block sits a flash engine. The front-end hands that engine an opcode and a 16-bit argument with a one-cycle start pulse. The engine later answers with a done pulse, which carries a lock-violation flag, a program-failure flag and a 32-bit result word. ECC single and multiple error events for the low and high halves of the data bus may arrive from the engine at any time.

A command write takes effect only when its top byte carries the command key. Undefined opcodes are rejected, and so is any keyed command issued while an operation is still running. Each status flag has its own clear rule:
- the command error clears on a status read or on the next keyed command write;
- the lock error and the ECC flags clear on a status read;
- the flash error clears only when a programming operation starts.

The mode register holds the ready-interrupt enable, the wait states and two option bits. It is locked by a separate write-protection register, which itself needs a 24-bit key to change. The interrupt line is the ready-interrupt enable ANDed with the ready flag.

Top module: `flash_cmd_frontend`

## Requirements
- R1: After reset, ready (status bit 0) is 1 and every other status bit, the mode register, the result register, the write-protection enable and the interrupt output are 0.
- R2: A write to offset 0x04 whose bits [31:24] differ from 0x5A has no effect: no start pulse is issued, no opcode or argument is passed on, and the status flags, including the command error bit, keep their values.
- R3: A keyed write to offset 0x04 with a valid opcode (0x00–0x05 or 0x07–0x15), issued while ready is 1, raises the engine start for exactly one cycle. The start begins on the clock edge that takes the write. Bits [7:0] are passed on as the opcode and bits [23:8] as the argument. Ready goes to 0 on that same edge.
- R4: Ready returns to 1 on the clock edge that samples engine done while busy. The engine result word is captured then and is read back at offset 0x0C.
- R5: A keyed command with opcode 0x06 or an opcode above 0x15, or any keyed command written while ready is 0, sets the command error (status bit 1) and starts nothing.
- R6: The command error clears on a status read at offset 0x08, and also on a keyed command write that is itself accepted.
- R7: The lock error (status bit 2, set by done with lock violation) and the ECC flags are sticky. The ECC flags sit at bit 16 (single, low half), bit 17 (multiple, low half), bit 18 (single, high half) and bit 19 (multiple, high half), and are set by the engine's 4-bit ECC event input in that bit order. All of these clear on a status read, and that read returns their value from before the clear.
- R8: The flash error (status bit 3) is set by done with program failure. It is not cleared by reads. It clears only when a programming opcode (0x01–0x05, 0x07, 0x11–0x13) is started.
- R9: A write to offset 0x00 stores the write data ANDed with 0x04010F01, but only while write protection is disabled. While protection is enabled the write is ignored.
- R10: A write to offset 0xE4 updates the write-protection enable from bit 0 only if bits [31:8] equal 0x454643. Reading 0xE4 returns the enable in bit 0 and zero elsewhere.
- R11: The interrupt output equals mode bit 0 AND ready.
- R12: Reads of the write-only command offset 0x04 and of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| eng_start | output | 1 | One-cycle operation start |
| eng_opcode | output | 8 | Opcode of the started operation |
| eng_arg | output | 16 | Argument of the started operation |
| eng_done | input | 1 | Operation finished pulse |
| eng_lock_err | input | 1 | Finished operation hit a locked region |
| eng_prog_fail | input | 1 | Finished operation failed to program |
| eng_ecc | input | 4 | ECC events: single low, multiple low, single high, multiple high |
| eng_result | input | 32 | Result word valid with done |
| irq_ready | output | 1 | Ready interrupt |

## Verification
The bench builds the block with its default 8-bit address width. That width is wide enough to decode the protection register at 0xE4, which brings every register offset within reach, and it also lets the bench probe unmapped offsets. The random mix covers several interleavings:
- wrong and right command keys;
- busy-time commands;
- the whole opcode space 0x00–0x17, including the hole at 0x06 and values past the end;
- protection toggles between mode writes;
- ECC bursts between status reads.

Directed cases pin down the edges where two clear and set rules meet.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  localparam int unsigned DW          = 32;
  localparam int unsigned OFF_MODE    = 'h00;
  localparam int unsigned OFF_CMD     = 'h04;
  localparam int unsigned OFF_STAT    = 'h08;
  localparam int unsigned OFF_RES     = 'h0C;
  localparam int unsigned OFF_WPROT   = 'hE4;
  localparam logic [7:0]  CMD_KEY     = 8'h5A;
  localparam logic [23:0] WPROT_KEY   = 24'h454643;
  localparam logic [31:0] MODE_MASK   = 32'h0401_0F01;
  localparam int unsigned ECC_N       = 4;
  localparam logic [7:0]  OP_LAST     = 8'h15;
  localparam logic [7:0]  OP_HOLE     = 8'h06;

  // Opcode is defined when within the table and not the single gap.
  function automatic logic op_is_valid(input logic [7:0] op);
    return (op <= OP_LAST) && (op != OP_HOLE);
  endfunction

  // Opcodes that write or erase the array (clear the flash error on start).
  function automatic logic op_is_program(input logic [7:0] op);
    case (op)
      8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h07,
      8'h11, 8'h12, 8'h13: return 1'b1;
      default:             return 1'b0;
    endcase
  endfunction

  // Status word layout: ready, cmd err, lock err, flash err, ECC at 16+.
  function automatic logic [DW-1:0] pack_status(input logic rdy, input logic cerr,
                                                input logic lerr, input logic ferr,
                                                input logic [ECC_N-1:0] ecc);
    logic [DW-1:0] w;
    w = '0;
    w[0] = rdy;
    w[1] = cerr;
    w[2] = lerr;
    w[3] = ferr;
    w[16 +: ECC_N] = ecc;
    return w;
  endfunction
endpackage

// File: rtl/fe_cmd_gate.sv
module fe_cmd_gate
  import flash_fe_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [DW-1:0] wdata,
  input  logic          ready,
  output logic          cmd_keyed,
  output logic          cmd_launch,
  output logic          cmd_reject,
  output logic          launch_prog,
  output logic          start_q,
  output logic [7:0]    op_q,
  output logic [15:0]   arg_q
);
  logic [7:0] op_in;
  logic       op_ok;

  assign op_in       = wdata[7:0];
  assign op_ok       = op_is_valid(op_in);
  assign cmd_keyed   = cmd_wr && (wdata[31:24] == CMD_KEY);
  assign cmd_launch  = cmd_keyed && op_ok && ready;
  assign cmd_reject  = cmd_keyed && !(op_ok && ready);
  assign launch_prog = cmd_launch && op_is_program(op_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      op_q    <= '0;
      arg_q   <= '0;
    end else begin
      start_q <= cmd_launch;
      if (cmd_launch) begin
        op_q  <= op_in;
        arg_q <= wdata[23:8];
      end
    end
  end
endmodule

// File: rtl/fe_status_flags.sv
module fe_status_flags
  import flash_fe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_keyed,
  input  logic             cmd_launch,
  input  logic             cmd_reject,
  input  logic             launch_prog,
  input  logic             st_rd,
  input  logic             eng_done,
  input  logic             eng_lock_err,
  input  logic             eng_prog_fail,
  input  logic [ECC_N-1:0] eng_ecc,
  input  logic [DW-1:0]    eng_result,
  output logic             ready_q,
  output logic             cmd_err_q,
  output logic             lock_err_q,
  output logic             flash_err_q,
  output logic [ECC_N-1:0] ecc_q,
  output logic [DW-1:0]    result_q
);
  logic done_ev;
  assign done_ev = eng_done && !ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q     <= 1'b1;
      cmd_err_q   <= 1'b0;
      lock_err_q  <= 1'b0;
      flash_err_q <= 1'b0;
      result_q    <= '0;
    end else begin
      if (cmd_launch)   ready_q <= 1'b0;
      else if (done_ev) ready_q <= 1'b1;

      if (cmd_keyed)  cmd_err_q <= cmd_reject;
      else if (st_rd) cmd_err_q <= 1'b0;

      if (done_ev && eng_lock_err) lock_err_q <= 1'b1;
      else if (st_rd)              lock_err_q <= 1'b0;

      if (launch_prog)                   flash_err_q <= 1'b0;
      else if (done_ev && eng_prog_fail) flash_err_q <= 1'b1;

      if (done_ev) result_q <= eng_result;
    end
  end

  for (genvar i = 0; i < ECC_N; i++) begin : g_ecc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ecc_q[i] <= 1'b0;
      else if (eng_ecc[i]) ecc_q[i] <= 1'b1;
      else if (st_rd)      ecc_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/fe_config_regs.sv
module fe_config_regs
  import flash_fe_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wr,
  input  logic          wprot_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mode_q,
  output logic          wp_en_q,
  output logic          mode_wr_ev
);
  assign mode_wr_ev = mode_wr && !wp_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      wp_en_q <= 1'b0;
    end else begin
      if (mode_wr_ev) mode_q <= wdata & MODE_MASK;
      if (wprot_wr && (wdata[31:8] == WPROT_KEY)) wp_en_q <= wdata[0];
    end
  end
endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
  import flash_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              eng_start,
  output logic [7:0]        eng_opcode,
  output logic [15:0]       eng_arg,
  input  logic              eng_done,
  input  logic              eng_lock_err,
  input  logic              eng_prog_fail,
  input  logic [ECC_N-1:0]  eng_ecc,
  input  logic [DW-1:0]     eng_result,
  output logic              irq_ready
);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFF_MODE);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_RES   = ADDR_W'(OFF_RES);
  localparam logic [ADDR_W-1:0] A_WPROT = ADDR_W'(OFF_WPROT);

  // Named access events
  logic wr_ev, rd_ev;
  logic cmd_wr, mode_wr, wprot_wr, st_rd;
  assign wr_ev    = bus_sel && bus_wr;
  assign rd_ev    = bus_sel && !bus_wr;
  assign cmd_wr   = wr_ev && (bus_addr == A_CMD);
  assign mode_wr  = wr_ev && (bus_addr == A_MODE);
  assign wprot_wr = wr_ev && (bus_addr == A_WPROT);
  assign st_rd    = rd_ev && (bus_addr == A_STAT);

  logic cmd_keyed, cmd_launch, cmd_reject, launch_prog;
  logic ready_q, cmd_err_q, lock_err_q, flash_err_q;
  logic [ECC_N-1:0] ecc_q;
  logic [DW-1:0] result_q, mode_q;
  logic wp_en_q, mode_wr_ev;

  fe_cmd_gate u_gate (
    .clk, .rst_n, .cmd_wr, .wdata(bus_wdata), .ready(ready_q),
    .cmd_keyed, .cmd_launch, .cmd_reject, .launch_prog,
    .start_q(eng_start), .op_q(eng_opcode), .arg_q(eng_arg)
  );

  fe_status_flags u_flags (
    .clk, .rst_n, .cmd_keyed, .cmd_launch, .cmd_reject, .launch_prog, .st_rd,
    .eng_done, .eng_lock_err, .eng_prog_fail, .eng_ecc, .eng_result,
    .ready_q, .cmd_err_q, .lock_err_q, .flash_err_q, .ecc_q, .result_q
  );

  fe_config_regs u_cfg (
    .clk, .rst_n, .mode_wr, .wprot_wr, .wdata(bus_wdata),
    .mode_q, .wp_en_q, .mode_wr_ev
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_ev) begin
      case (bus_addr)
        A_MODE:  bus_rdata = mode_q;
        A_STAT:  bus_rdata = pack_status(ready_q, cmd_err_q, lock_err_q, flash_err_q, ecc_q);
        A_RES:   bus_rdata = result_q;
        A_WPROT: bus_rdata = {{(DW-1){1'b0}}, wp_en_q};
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq_ready = mode_q[0] && ready_q;
endmodule

// File: rtl/flash_fe_checker.sv
module flash_fe_checker #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              eng_start,
  input logic              eng_done,
  input logic              eng_prog_fail,
  input logic              ready_q,
  input logic              lock_err_q,
  input logic              flash_err_q,
  input logic              st_rd,
  input logic              wp_en_q,
  input logic [31:0]       mode_q,
  input logic              irq_ready
);
  AST_START_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $past(bus_sel && bus_wr && bus_addr == ADDR_W'(4) && bus_wdata[31:24] == 8'h5A)); // R2
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !ready_q); // R3
  AST_START_WAS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $past(ready_q)); // R5
  AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !$past(ready_q)) |-> $past(eng_done)); // R4
  AST_FLERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_err_q && !$past(flash_err_q)) |-> $past(eng_done && eng_prog_fail)); // R8
  AST_LOCK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_err_q && $past(lock_err_q)) |-> $past(st_rd)); // R7
  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wp_en_q) |-> $stable(mode_q)); // R9
  AST_IRQ_READY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ready |-> ready_q); // R11
endmodule

bind flash_cmd_frontend flash_fe_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .eng_start(eng_start), .eng_done(eng_done),
  .eng_prog_fail(eng_prog_fail), .ready_q(ready_q), .lock_err_q(lock_err_q),
  .flash_err_q(flash_err_q), .st_rd(st_rd), .wp_en_q(wp_en_q), .mode_q(mode_q),
  .irq_ready(irq_ready)
);

// File: tb/flash_cmd_frontend_tb.sv
module flash_cmd_frontend_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        eng_start;
  logic [7:0]  eng_opcode;
  logic [15:0] eng_arg;
  logic        eng_done = 1'b0, eng_lock_err = 1'b0, eng_prog_fail = 1'b0;
  logic [3:0]  eng_ecc = '0;
  logic [31:0] eng_result = '0;
  logic        irq_ready;

  flash_cmd_frontend u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model
  logic        m_ready = 1, m_cerr = 0, m_lock = 0, m_ferr = 0, m_wp = 0;
  logic [3:0]  m_ecc = 0;
  logic [31:0] m_mode = 0, m_res = 0;

  function automatic bit b_valid(input logic [7:0] op);
    return (op < 8'h16) && (op != 8'h06);
  endfunction
  function automatic bit b_prog(input logic [7:0] op);
    return (op >= 8'h01 && op <= 8'h05) || op == 8'h07 || (op >= 8'h11 && op <= 8'h13);
  endfunction
  function automatic logic [31:0] b_status();
    return {12'd0, m_ecc, 12'd0, m_ferr, m_lock, m_cerr, m_ready};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic do_cmd(input logic [31:0] w);
    bit exp_start = 0;
    if (w[31:24] == 8'h5A) begin
      m_cerr = 0;
      if (b_valid(w[7:0]) && m_ready) begin
        exp_start = 1; m_ready = 0;
        if (b_prog(w[7:0])) m_ferr = 0;
      end else m_cerr = 1;
    end
    bus_write(8'h04, w);
    check(eng_start === exp_start, w[31:24] == 8'h5A ? "R3/R5 start" : "R2 bad key", {31'd0, eng_start}, {31'd0, exp_start});
    if (exp_start)
      check({eng_arg, eng_opcode} === w[23:0], "R3 fields", {8'd0, eng_arg, eng_opcode}, {8'd0, w[23:0]});
    @(negedge clk);
    check(eng_start === 1'b0, "R3 one-cycle start", {31'd0, eng_start}, 0);
  endtask

  task automatic finish_op(input logic lk, input logic pf, input logic [31:0] r);
    @(negedge clk);
    eng_done = 1; eng_lock_err = lk; eng_prog_fail = pf; eng_result = r;
    @(negedge clk);
    eng_done = 0; eng_lock_err = 0; eng_prog_fail = 0;
    if (!m_ready) begin
      m_ready = 1; m_res = r;
      if (lk) m_lock = 1;
      if (pf) m_ferr = 1;
    end
  endtask

  task automatic read_status();
    logic [31:0] d;
    bus_read(8'h08, d);
    check(d === b_status(), "R6/R7/R8 status", d, b_status());
    m_cerr = 0; m_lock = 0; m_ecc = 0;
  endtask

  task automatic pulse_ecc(input logic [3:0] v);
    @(negedge clk); eng_ecc = v;
    @(negedge clk); eng_ecc = 0;
    m_ecc |= v;
  endtask

  task automatic write_mode(input logic [31:0] d);
    if (!m_wp) m_mode = d & 32'h0401_0F01;
    bus_write(8'h00, d);
  endtask

  task automatic write_wp(input logic [31:0] d);
    if (d[31:8] == 24'h454643) m_wp = d[0];
    bus_write(8'hE4, d);
  endtask

  task automatic check_regs();
    logic [31:0] d;
    bus_read(8'h00, d); check(d === m_mode, "R9 mode", d, m_mode);
    bus_read(8'hE4, d); check(d === {31'd0, m_wp}, "R10 wprot", d, {31'd0, m_wp});
    bus_read(8'h0C, d); check(d === m_res, "R4 result", d, m_res);
    check(irq_ready === (m_mode[0] & m_ready), "R11 irq", {31'd0, irq_ready}, {31'd0, m_mode[0] & m_ready});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    #1 check(irq_ready === 0 && eng_start === 0, "R1 outputs", {30'd0, irq_ready, eng_start}, 0);
    read_status();
    bus_read(8'h00, d); check(d === 0, "R1 mode", d, 0);
    bus_read(8'h0C, d); check(d === 0, "R1 result", d, 0);
    bus_read(8'hE4, d); check(d === 0, "R1 wprot", d, 0);
    // R12 write-only and unmapped reads
    bus_read(8'h04, d); check(d === 0, "R12 cmd reads zero", d, 0);
    bus_read(8'h40, d); check(d === 0, "R12 unmapped", d, 0);
    // R5 hole opcode then R2 bad key leaves error set, R6 good command clears
    do_cmd(32'h5A00_0006); read_status();
    do_cmd(32'h5A00_0016); do_cmd(32'hA500_0001); read_status();
    do_cmd(32'h5A00_00FF); do_cmd(32'h5A12_3415);
    finish_op(0, 0, 32'hCAFE_0001); check_regs(); read_status();
    // R8 flash error: set, survives reads and non-program start, cleared by program start
    do_cmd(32'h5A00_0001); finish_op(0, 1, 32'h1); read_status(); read_status();
    do_cmd(32'h5A00_000A); finish_op(1, 0, 32'h2); read_status(); read_status();
    do_cmd(32'h5A00_0011); read_status(); finish_op(0, 0, 32'h3); read_status();
    // R5 busy rejection
    do_cmd(32'h5A00_0005); do_cmd(32'h5A00_0008); read_status(); finish_op(0, 0, 32'h4);
    // R7 ECC bit order
    pulse_ecc(4'b0001); pulse_ecc(4'b1000); read_status(); read_status();
    // R9/R10 protection
    write_mode(32'hFFFF_FFFF); check_regs();
    write_wp(32'h4546_4300); write_wp(32'h4546_4401); write_mode(32'h0); check_regs();
    write_wp(32'h4546_4301); write_mode(32'h0); check_regs();
    write_wp(32'h4546_4300); write_mode(32'h0000_0001); check_regs();
    // random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned sel = $urandom % 8;
      logic [31:0] w = $urandom;
      case (sel)
        0, 1: begin
          if (($urandom % 4) != 0) w[31:24] = 8'h5A;
          w[7:0] = 8'($urandom % 24);
          do_cmd(w);
        end
        2: finish_op(1'($urandom), 1'($urandom), $urandom);
        3: read_status();
        4: pulse_ecc(4'($urandom));
        5: write_mode(w);
        6: begin
          if (($urandom % 2) != 0) w[31:8] = 24'h454643;
          write_wp(w);
        end
        default: check_regs();
      endcase
    end
    read_status(); check_regs();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule